// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Unit

This peripheral gives every hart of a multi-hart cluster two interrupt sources. A single 64-bit time counter, shared by all harts, advances by one on each cycle in which the tick-enable input is high. Each hart has its own 64-bit compare value. Its timer interrupt line stays high for as long as the time counter is at or above that value, so software clears the interrupt by moving the compare value forward. Each hart also has a one-bit software-interrupt flag. Any hart sets the flag to signal another hart, and the flag stays set until it is written back to zero.

All state sits behind one 32-bit register port that has address, write-enable, write-data and read-data signals. Reads are combinational from the address. A write takes effect at the rising clock edge. The 64-bit quantities are split into a low word and a high word at consecutive word offsets. Any filtering by privilege level, any bus bridging, and the generation of the tick all happen outside the unit.

Top module: `hart_timer_swi`

## Requirements
- R1: After a synchronous reset the time counter reads 0, every compare register reads all ones, every software flag reads 0, and all interrupt outputs are low.
- R2: The time counter grows by exactly one on each clock edge at which `tick` is high and no time write occurs. It holds its value while `tick` is low. A carry out of the low word propagates into the high word.
- R3: The time counter's low word is at offset 0xBFF8 and its high word is at 0xBFFC. A write to one word leaves the other word unchanged. When a time write and `tick` fall in the same cycle, the written value is kept and the increment is dropped.
- R4: The compare register of hart h has its low word at 0x4000+8h and its high word at 0x4000+8h+4. Writing one word leaves the other word unchanged.
- R5: `tmr_irq[h]` is high exactly when the 64-bit unsigned time counter is greater than or equal to compare register h. It follows register updates without delay and drops again when the compare value is raised above the time counter or the time counter is lowered below it.
- R6: The software flag of hart h is bit 0 of the word at offset 4h. A write with bit 0 = 1 sets the flag and a write with bit 0 = 0 clears it. With no write the flag keeps its value, and `sw_irq[h]` mirrors it.
- R7: Bits 31:1 of every software-flag word read as zero, and whatever is written to them has no effect.
- R8: Reads of an unmapped offset return zero, and writes to an unmapped offset change nothing. Unmapped offsets include any offset with bits 1:0 not zero, slots past the last hart, and the space between the two maps.
- R9: Through the single port every hart's slots can be accessed, and a write changes at most one word of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time counter advance enable |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| tmr_irq | output | N_HARTS | Level timer interrupt per hart |
| sw_irq | output | N_HARTS | Software interrupt per hart |

## Verification
The bench probes the equality boundary of the compare: it moves the compare value one below, equal to and one above the time counter. A design that used a strict greater-than would miss the equal case. The bench also raises only the compare high word, which catches a design that compared only the low words. It writes single halves and then reads back the opposite half, which exposes a decode that updates both words. It writes time while the tick is active, and it runs a low-word carry, which an increment that is 32 bits wide would lose. Finally it covers the slot just past the last hart, misaligned offsets, and all-ones data sent to the software words. These show up aliasing or a flag register that is wider than one bit.

// File: rtl/hts_pkg.sv
package hts_pkg;

    localparam int REG_W = 32;
    localparam int CNT_W = 64;
    localparam int IDX_W = 12;

    localparam logic [31:0] CMP_BASE  = 32'h0000_4000;
    localparam logic [31:0] TIME_BASE = 32'h0000_BFF8;
    localparam logic [31:0] MAP_END   = 32'h0000_C000;
    localparam logic [29:0] CMP_WORD0 = 30'h0000_1000;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SWI,
        ACC_CMP,
        ACC_TIME
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [IDX_W-1:0]   idx;
        logic               hi;
    } acc_t;

    function automatic logic [REG_W-1:0] word_of(input logic [CNT_W-1:0] v,
                                                 input logic hi);
        return hi ? v[CNT_W-1:REG_W] : v[REG_W-1:0];
    endfunction

endpackage

// File: rtl/hts_decode.sv
module hts_decode
    import hts_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int ADDR_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);

    logic [31:0] a;
    logic [29:0] cw;

    always_comb begin
        a   = 32'(addr);
        cw  = a[31:2] - CMP_WORD0;
        acc = '{ACC_NONE, '0, 1'b0};
        if (a[1:0] == 2'b00) begin
            if (a < CMP_BASE) begin
                if ({2'b00, a[31:2]} < 32'(N_HARTS)) begin
                    acc.kind = ACC_SWI;
                    acc.idx  = a[2 +: IDX_W];
                end
            end else if (a < TIME_BASE) begin
                if ({3'b000, cw[29:1]} < 32'(N_HARTS)) begin
                    acc.kind = ACC_CMP;
                    acc.idx  = cw[1 +: IDX_W];
                    acc.hi   = cw[0];
                end
            end else if (a < MAP_END) begin
                acc.kind = ACC_TIME;
                acc.hi   = a[2];
            end
        end
    end

endmodule

// File: rtl/hts_timebase.sv
module hts_timebase
    import hts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_lo) cnt[REG_W-1:0] <= wdata;
        else if (wr_hi) cnt[CNT_W-1:REG_W] <= wdata;
        else if (tick)  cnt <= cnt + CNT_W'(1);
    end

    // R2: one step per enabled tick
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_lo && !wr_hi) |=> cnt == $past(cnt) + CNT_W'(1));

    // R2: frozen without tick
    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt));

    // R3: half writes leave the other half alone
    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> cnt[CNT_W-1:REG_W] == $past(cnt[CNT_W-1:REG_W]));

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> cnt[REG_W-1:0] == $past(cnt[REG_W-1:0]));

endmodule

// File: rtl/hts_hart_slot.sv
module hts_hart_slot
    import hts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_wr_lo,
    input  logic             cmp_wr_hi,
    input  logic             swi_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] time_now,
    output logic [CNT_W-1:0] cmp_q,
    output logic             swi_pend,
    output logic             tmr_irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
        end else begin
            if (cmp_wr_lo) cmp_q[REG_W-1:0]     <= wdata;
            if (cmp_wr_hi) cmp_q[CNT_W-1:REG_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         swi_pend <= 1'b0;
        else if (swi_wr) swi_pend <= wdata[0];
    end

    assign tmr_irq = (time_now >= cmp_q);

    // R6: flag is sticky and only a write moves it
    p_swi_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (swi_pend && !swi_wr) |=> swi_pend);

    p_swi_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!swi_pend && !swi_wr) |=> !swi_pend);

    p_swi_follow_r6: assert property (@(posedge clk) disable iff (rst)
        swi_wr |=> swi_pend == $past(wdata[0]));

    // R4: halves of the compare are independent
    p_cmp_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_wr_lo |=> cmp_q[CNT_W-1:REG_W] == $past(cmp_q[CNT_W-1:REG_W]));

    p_cmp_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!cmp_wr_lo && !cmp_wr_hi) |=> $stable(cmp_q));

endmodule

// File: rtl/hart_timer_swi.sv
module hart_timer_swi
    import hts_pkg::*;
#(
    parameter int N_HARTS = 4,
    parameter int ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    output logic [N_HARTS-1:0] tmr_irq,
    output logic [N_HARTS-1:0] sw_irq
);

    localparam int STROBES = 3 * N_HARTS + 2;

    acc_t               acc;
    logic               time_wr_lo;
    logic               time_wr_hi;
    logic [N_HARTS-1:0] cmp_wr_lo;
    logic [N_HARTS-1:0] cmp_wr_hi;
    logic [N_HARTS-1:0] swi_wr;
    logic [CNT_W-1:0]   time_q;
    logic [CNT_W-1:0]   cmp_q [N_HARTS];
    logic [STROBES-1:0] strobes;

    hts_decode #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .acc  (acc)
    );

    assign time_wr_lo = bus_we && (acc.kind == ACC_TIME) && !acc.hi;
    assign time_wr_hi = bus_we && (acc.kind == ACC_TIME) &&  acc.hi;

    hts_timebase u_time (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_lo (time_wr_lo),
        .wr_hi (time_wr_hi),
        .wdata (bus_wdata),
        .cnt   (time_q)
    );

    for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
        logic hit;
        assign hit          = (acc.idx == IDX_W'(h));
        assign cmp_wr_lo[h] = bus_we && (acc.kind == ACC_CMP) && hit && !acc.hi;
        assign cmp_wr_hi[h] = bus_we && (acc.kind == ACC_CMP) && hit &&  acc.hi;
        assign swi_wr[h]    = bus_we && (acc.kind == ACC_SWI) && hit;

        hts_hart_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .cmp_wr_lo (cmp_wr_lo[h]),
            .cmp_wr_hi (cmp_wr_hi[h]),
            .swi_wr    (swi_wr[h]),
            .wdata     (bus_wdata),
            .time_now  (time_q),
            .cmp_q     (cmp_q[h]),
            .swi_pend  (sw_irq[h]),
            .tmr_irq   (tmr_irq[h])
        );

        // R5: a raised timer line stays up while nothing is rewritten
        p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (tmr_irq[h] && !cmp_wr_lo[h] && !cmp_wr_hi[h] && !time_wr_lo && !time_wr_hi)
            |=> tmr_irq[h]);

        // R5: a low timer line stays low with no tick and no writes
        p_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
            (!tmr_irq[h] && !tick && !cmp_wr_lo[h] && !cmp_wr_hi[h]
             && !time_wr_lo && !time_wr_hi) |=> !tmr_irq[h]);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (acc.kind)
            ACC_SWI: begin
                for (int h = 0; h < N_HARTS; h++)
                    if (acc.idx == IDX_W'(h))
                        bus_rdata = {{(REG_W-1){1'b0}}, sw_irq[h]};
            end
            ACC_CMP: begin
                for (int h = 0; h < N_HARTS; h++)
                    if (acc.idx == IDX_W'(h))
                        bus_rdata = word_of(cmp_q[h], acc.hi);
            end
            ACC_TIME: bus_rdata = word_of(time_q, acc.hi);
            default:  bus_rdata = '0;
        endcase
    end

    assign strobes = {time_wr_lo, time_wr_hi, cmp_wr_lo, cmp_wr_hi, swi_wr};

    // R9: at most one word of state is written per access
    p_single_target_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    // R8: unmapped offsets read as zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == ACC_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_hart_timer_swi.sv
`timescale 1ns/1ps
module sim_hart_timer_swi;

    localparam int NH = 4;
    localparam int AW = 16;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    // reads carry the expected value in data
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h4000, 32'h1234_5678, 4'd4},  // R4 cmp0 low
        '{1'b0, 16'h4000, 32'h1234_5678, 4'd4},
        '{1'b0, 16'h4004, 32'hFFFF_FFFF, 4'd4},  // R4 high untouched
        '{1'b1, 16'h401C, 32'h0000_0000, 4'd4},  // cmp3 high
        '{1'b0, 16'h4018, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 16'h401C, 32'h0000_0000, 4'd4},
        '{1'b1, 16'h0008, 32'hFFFF_FFFF, 4'd7},  // R7 all ones to swi2
        '{1'b0, 16'h0008, 32'h0000_0001, 4'd7},
        '{1'b1, 16'h0008, 32'hFFFF_FFFE, 4'd6},  // R6 clear via bit0
        '{1'b0, 16'h0008, 32'h0000_0000, 4'd6},
        '{1'b1, 16'h0004, 32'h0000_0003, 4'd6},  // R6 set swi1
        '{1'b0, 16'h0004, 32'h0000_0001, 4'd6},
        '{1'b1, 16'h0010, 32'h0000_0001, 4'd8},  // R8 slot past last hart
        '{1'b0, 16'h0010, 32'h0000_0000, 4'd8},
        '{1'b0, 16'h4020, 32'h0000_0000, 4'd8},
        '{1'b1, 16'h4020, 32'h0000_0005, 4'd8},
        '{1'b0, 16'h4020, 32'h0000_0000, 4'd8},
        '{1'b0, 16'h0002, 32'h0000_0000, 4'd8},  // R8 misaligned
        '{1'b1, 16'h4001, 32'h0000_0000, 4'd8},
        '{1'b0, 16'h4000, 32'h1234_5678, 4'd8},
        '{1'b0, 16'hBFFC, 32'h0000_0000, 4'd3},  // R3 time high
        '{1'b0, 16'h8000, 32'h0000_0000, 4'd9}   // R9 cmp region gap
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] tmr_irq;
    logic [NH-1:0] sw_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    hart_timer_swi #(.N_HARTS(NH), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq),
        .sw_irq    (sw_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(16'hBFF8, v);  chk("R1 time low", 64'(v), 64'h0);
        rd(16'h4004, v);  chk("R1 cmp0 high", 64'(v), 64'hFFFF_FFFF);
        rd(16'h0000, v);  chk("R1 swi0", 64'(v), 64'h0);
        chk("R1 irq lines", 64'({tmr_irq, sw_irq}), 64'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].addr, v);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(v), 64'(VECS[i].data));
            end
        end

        // R2: time held while tick low
        rd(16'hBFF8, v);  chk("R2 hold without tick", 64'(v), 64'h0);

        // R6: flag drives port, clears, sticks
        chk("R6 sw_irq after table", 64'(sw_irq), 64'h2);
        wr(16'h0004, 32'h0);
        chk("R6 clear swi1", 64'(sw_irq), 64'h0);
        wr(16'h000C, 32'h1);
        repeat (5) @(negedge clk);
        chk("R6 sticky swi3", 64'(sw_irq), 64'h8);
        rd(16'h000C, v);  chk("R6 read swi3", 64'(v), 64'h1);

        // R3: time halves writable
        wr(16'hBFF8, 32'd100);
        wr(16'hBFFC, 32'd0);
        rd(16'hBFF8, v);  chk("R3 time low write", 64'(v), 64'd100);

        // R2: ten ticks
        run_ticks(10);
        rd(16'hBFF8, v);  chk("R2 ten ticks", 64'(v), 64'd110);

        // R5: compare boundaries, time = 110
        wr(16'h400C, 32'd0);
        wr(16'h4008, 32'd111);
        chk("R5 cmp one above", 64'(tmr_irq), 64'h0);
        wr(16'h4008, 32'd110);
        chk("R5 cmp equal", 64'(tmr_irq), 64'h2);
        wr(16'h4008, 32'd109);
        chk("R5 cmp below", 64'(tmr_irq), 64'h2);
        wr(16'h400C, 32'd1);
        chk("R4 R5 high word raises cmp", 64'(tmr_irq), 64'h0);

        // R5: time crossing
        wr(16'h4014, 32'd0);
        wr(16'h4010, 32'd113);
        run_ticks(2);
        chk("R5 before crossing", 64'(tmr_irq), 64'h0);
        run_ticks(1);
        chk("R5 at crossing", 64'(tmr_irq), 64'h4);

        // R3: write wins over tick in same cycle
        @(negedge clk);
        tick = 1'b1; bus_we = 1'b1; bus_addr = 16'hBFF8; bus_wdata = 32'd5;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        rd(16'hBFF8, v);  chk("R3 write beats tick", 64'(v), 64'd5);
        chk("R5 drops after time lowered", 64'(tmr_irq), 64'h0);

        // R2: carry into high word
        wr(16'hBFF8, 32'hFFFF_FFFF);
        run_ticks(1);
        rd(16'hBFF8, v);
        rd(16'hBFFC, v2);
        chk("R2 carry", {v2, v}, 64'h1_0000_0000);
        chk("R5 after carry", 64'(tmr_irq), 64'hC);

        summary();
        $finish;
    end

endmodule